// File: doc/BRIEF.md
# Oscillator Settling Wait Timer

This block keeps the processor from running on a crystal clock that has not yet settled after a low-power stop ends. Software picks one of five power-of-two wait lengths through a small select register. When the stop state is released, a counter clocked by the oscillator counts up to the chosen length. The block then raises a ready signal toward clock control.

A sticky status vector records each settling threshold the counter has reached. When the processor runs from an internal oscillator, it is not held. Software then reads the status to learn how long the crystal has been running. The wait starts at the first oscillator edge that sees the release. Time before the oscillator starts toggling is therefore not counted.

The bus side is an 8-bit register port. It has write and read strobes, one address bit that picks the select register (0) or the status register (1), and read data registered one cycle after the read strobe. All logic runs on the oscillator clock.

Top module: `osc_settle_timer`

## Requirements
- R1: After reset the select register reads 8'h05, the status register reads 8'h00, `ready` is 1 and `cpu_hold` is 0.
- R2: A write to address 0 while no wait is running stores `bus_wdata[2:0]`. A read of address 0 returns that code in bits [2:0] with bits [7:3] zero. Read data appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`.
- R3: Codes 1, 2, 3, 4 and 5 select waits of 2^11, 2^13, 2^14, 2^15 and 2^16 cycles. With L the selected length, `ready` is 0 for the L cycles after the edge that samples `stop_release`, and it is 1 from the following edge onward.
- R4: If code 0, 6 or 7 is held when a wait begins, the wait lasts 2^16 cycles.
- R5: `cpu_hold` is 1 during a wait only if `xtal_is_cpu` was 1 at the release edge. Otherwise it stays 0, while `ready` and the status still follow R3 and R6.
- R6: Status bits 0 to 4 stand for the thresholds 2^11, 2^13, 2^14, 2^15 and 2^16. Each bit sets when the counter reaches its threshold and stays set. The counter stops at the selected length, so bits for longer thresholds stay 0 however long the block then waits.
- R7: A write to address 0 during a wait is ignored: the code reads back unchanged after the wait. In the cycle after that write's edge, `wr_blocked` is 1 for exactly one cycle.
- R8: `stop_enter` clears `ready` and all status bits on the next edge. A `stop_release` that arrives while not stopped has no effect.
- R9: Writes to address 1 have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_enter | input | 1 | One-cycle pulse: stop state entered |
| stop_release | input | 1 | One-cycle pulse: stop state released |
| xtal_is_cpu | input | 1 | 1 when the crystal clock drives the CPU |
| bus_addr | input | 1 | 0 = select register, 1 = status register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cpu_hold | output | 1 | Holds the CPU while the crystal settles |
| ready | output | 1 | Settling wait complete |
| wr_blocked | output | 1 | One-cycle flag: a select write was refused |

## Verification
The wait is run with every legal length and with a prohibited code. Each run is timed edge by edge, so an off-by-one in the release capture, the limit compare or the ready register shows up as a one-cycle shift. Crystal and internal CPU clock runs alternate, which separates the hold gating from the counting that both modes share. The final status of each run shows whether the counter saturates at the right threshold rather than at the next one. Random code writes with random upper bits, plus random writes to the status address, check the field masking and the read-only status.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_STOP = 2'd1,
      ST_WAIT = 2'd2
   } settle_state_e;

   localparam int unsigned NUM_STEPS = 5;
   localparam int unsigned MAX_SHIFT = 16;

   // step index 0..4 -> log2 of threshold (11,13,14,15,16)
   function automatic int unsigned step_shift(input int unsigned idx);
      return (idx == 0) ? 11 : 12 + idx;
   endfunction

   // select code -> step index; prohibited codes fall to the longest step
   function automatic int unsigned code_step(input logic [2:0] code);
      case (code)
         3'd1:    return 0;
         3'd2:    return 1;
         3'd3:    return 2;
         3'd4:    return 3;
         3'd5:    return 4;
         default: return NUM_STEPS - 1;
      endcase
   endfunction

endpackage

// File: rtl/ost_select_reg.sv
module ost_select_reg #(
   parameter int unsigned SEL_W      = 3,
   parameter logic [2:0]  RESET_CODE = 3'd5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wdata,
   input  logic             locked,
   output logic [SEL_W-1:0] code,
   output logic             blocked
);

   if (SEL_W != 3) begin : g_bad_sel_w
      $error("ost_select_reg: SEL_W must be 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code    <= SEL_W'(RESET_CODE);
         blocked <= 1'b0;
      end else begin
         blocked <= wr_en && locked;
         if (wr_en && !locked) begin
            code <= wdata;
         end
      end
   end

   // R7: a refused write leaves the code untouched
   p_locked_keeps_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && locked) |=> $stable(code));

   // R7: the flag only follows a refused write
   p_blocked_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> $past(wr_en && locked));

endmodule

// File: rtl/ost_wait_ctrl.sv
module ost_wait_ctrl
   import osc_settle_pkg::*;
#(
   parameter int unsigned CNT_W = 17,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_enter,
   input  logic             stop_release,
   input  logic             xtal_is_cpu,
   input  logic [SEL_W-1:0] code,
   output logic             waiting,
   output logic             ready,
   output logic             cpu_hold,
   output logic [CNT_W-1:0] cnt
);

   if (CNT_W < MAX_SHIFT + 1) begin : g_bad_cnt_w
      $error("ost_wait_ctrl: CNT_W too small for the longest wait");
   end

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   settle_state_e    st_q;
   logic [CNT_W-1:0] lim_q;
   logic             xtal_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         lim_q  <= ONE << MAX_SHIFT;
         xtal_q <= 1'b0;
         cnt    <= '0;
         ready  <= 1'b1;
      end else if (stop_enter) begin
         st_q  <= ST_STOP;
         cnt   <= '0;
         ready <= 1'b0;
      end else begin
         case (st_q)
            ST_STOP: begin
               if (stop_release) begin
                  st_q   <= ST_WAIT;
                  lim_q  <= ONE << step_shift(code_step(3'(code)));
                  xtal_q <= xtal_is_cpu;
                  cnt    <= '0;
               end
            end
            ST_WAIT: begin
               if (cnt == lim_q) begin
                  st_q  <= ST_RUN;
                  ready <= 1'b1;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            default: begin
               st_q <= ST_RUN;
            end
         endcase
      end
   end

   assign waiting  = (st_q == ST_WAIT);
   assign cpu_hold = waiting && xtal_q;

   // R3: counter never runs past the latched limit
   p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim_q);

   // R3: ready only rises at the end of a wait
   p_ready_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(st_q == ST_WAIT));

   // R5: the CPU is never held while ready is shown
   p_hold_excl_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hold |-> !ready);

   // R8: stop entry drops ready
   p_stop_clears_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_enter |=> !ready);

   // R8: release outside a stop is ignored
   p_stray_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_release && !stop_enter && st_q == ST_RUN) |=> (ready && !waiting));

endmodule

// File: rtl/ost_status_flags.sv
module ost_status_flags
   import osc_settle_pkg::*;
#(
   parameter int unsigned CNT_W = 17
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 counting,
   input  logic [CNT_W-1:0]     cnt,
   output logic [NUM_STEPS-1:0] flags
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   for (genvar gi = 0; gi < NUM_STEPS; gi++) begin : g_step
      localparam logic [CNT_W-1:0] THR = ONE << step_shift(gi);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[gi] <= 1'b0;
         end else if (clear) begin
            flags[gi] <= 1'b0;
         end else if (counting && cnt == THR) begin
            flags[gi] <= 1'b1;
         end
      end
   end

   // R6: thresholds are passed in order, so set bits form a low prefix
   p_flags_prefix_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags + 1'b1) & flags) == '0);

   // R6: stop entry wipes every flag
   p_flags_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (flags == '0));

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
   import osc_settle_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned CNT_W      = 17,
   parameter logic [2:0]  RESET_CODE = 3'd5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_enter,
   input  logic              stop_release,
   input  logic              xtal_is_cpu,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cpu_hold,
   output logic              ready,
   output logic              wr_blocked
);

   if (DATA_W < NUM_STEPS || DATA_W <= SEL_W) begin : g_bad_data_w
      $error("osc_settle_timer: DATA_W too narrow for the register fields");
   end

   logic [SEL_W-1:0]     sel_code;
   logic                 waiting;
   logic [CNT_W-1:0]     cnt;
   logic [NUM_STEPS-1:0] flags;
   logic [DATA_W-1:0]    rd_mux;

   ost_select_reg #(.SEL_W(SEL_W), .RESET_CODE(RESET_CODE)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && !bus_addr),
      .wdata   (bus_wdata[SEL_W-1:0]),
      .locked  (waiting),
      .code    (sel_code),
      .blocked (wr_blocked)
   );

   ost_wait_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_wait (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_enter   (stop_enter),
      .stop_release (stop_release),
      .xtal_is_cpu  (xtal_is_cpu),
      .code         (sel_code),
      .waiting      (waiting),
      .ready        (ready),
      .cpu_hold     (cpu_hold),
      .cnt          (cnt)
   );

   ost_status_flags #(.CNT_W(CNT_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (stop_enter),
      .counting (waiting),
      .cnt      (cnt),
      .flags    (flags)
   );

   always_comb begin
      rd_mux = '0;
      if (bus_addr) begin
         rd_mux[NUM_STEPS-1:0] = flags;
      end else begin
         rd_mux[SEL_W-1:0] = sel_code;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_mux;
      end
   end

   // R2: only the low field of an accepted write lands in the code
   p_wr_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && !waiting && !stop_enter)
         |=> sel_code == $past(bus_wdata[SEL_W-1:0]));

   // R2: upper bits of a select read are zero
   p_rd_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_addr) |=> bus_rdata[DATA_W-1:SEL_W] == '0);

   // R9: bus writes never move the status flags
   p_status_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr && !waiting && !stop_enter) |=> $stable(flags));

endmodule

// File: tb/osc_settle_timer_test.sv
module osc_settle_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_enter = 1'b0;
   logic       stop_release = 1'b0;
   logic       xtal_is_cpu = 1'b0;
   logic       bus_addr = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cpu_hold;
   logic       ready;
   logic       wr_blocked;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   osc_settle_timer uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_enter   (stop_enter),
      .stop_release (stop_release),
      .xtal_is_cpu  (xtal_is_cpu),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .cpu_hold     (cpu_hold),
      .ready        (ready),
      .wr_blocked   (wr_blocked)
   );

   function automatic int exp_len(input logic [2:0] c);
      case (c)
         3'd1:    return 1 << 11;
         3'd2:    return 1 << 13;
         3'd3:    return 1 << 14;
         3'd4:    return 1 << 15;
         default: return 1 << 16;
      endcase
   endfunction

   function automatic logic [7:0] exp_status(input logic [2:0] c);
      case (c)
         3'd1:    return 8'h01;
         3'd2:    return 8'h03;
         3'd3:    return 8'h07;
         3'd4:    return 8'h0F;
         default: return 8'h1F;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse_stop();
      @(negedge clk);
      stop_enter = 1'b1;
      @(negedge clk);
      stop_enter = 1'b0;
   endtask

   task automatic run_wait(input logic [2:0] c, input bit xtal, input bit poke);
      logic [7:0] rd;
      int len, hold_bad, early;
      len = exp_len(c);
      hold_bad = 0;
      early = 0;
      bus_write(1'b0, {5'b10101, c});
      pulse_stop();
      chk(ready === 1'b0, "R8 ready after stop", 32'(ready), 0);
      bus_read(1'b1, rd);
      chk(rd === 8'h00, "R8 status cleared by stop", 32'(rd), 0);
      @(negedge clk);
      xtal_is_cpu = xtal;
      stop_release = 1'b1;
      @(posedge clk);
      @(negedge clk);
      stop_release = 1'b0;
      for (int k = 1; k <= len; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (cpu_hold !== xtal) hold_bad++;
         if (ready !== 1'b0) early++;
         if (poke && k == 8) begin
            bus_addr = 1'b0; bus_wdata = {5'b0, ~c}; bus_wr = 1'b1;
         end
         if (poke && k == 9) begin
            bus_wr = 1'b0;
            chk(wr_blocked === 1'b1, "R7 blocked flag set", 32'(wr_blocked), 1);
         end
         if (poke && k == 10)
            chk(wr_blocked === 1'b0, "R7 blocked flag one cycle", 32'(wr_blocked), 0);
      end
      chk(hold_bad == 0, xtal ? "R5 hold during crystal wait" : "R5 no hold on internal clock",
          32'(hold_bad), 0);
      chk(early == 0, "R3 ready low through wait", 32'(early), 0);
      @(posedge clk);
      @(negedge clk);
      chk(ready === 1'b1, "R3 ready one cycle after limit", 32'(ready), 1);
      chk(cpu_hold === 1'b0, "R5 hold released", 32'(cpu_hold), 0);
      bus_read(1'b1, rd);
      chk(rd === exp_status(c), (c == 0 || c > 5) ? "R4 status for prohibited code"
          : "R6 status at limit", 32'(rd), 32'(exp_status(c)));
      bus_read(1'b0, rd);
      chk(rd === {5'b0, c}, poke ? "R7 code kept after refused write" : "R2 code kept",
          32'(rd), 32'({5'b0, c}));
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd, st_before;
      logic [2:0] c;
      void'($urandom(32'h0051_7E11));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ready === 1'b1, "R1 ready at reset", 32'(ready), 1);
      chk(cpu_hold === 1'b0, "R1 hold at reset", 32'(cpu_hold), 0);
      bus_read(1'b0, rd);
      chk(rd === 8'h05, "R1 select reset value", 32'(rd), 32'h05);
      bus_read(1'b1, rd);
      chk(rd === 8'h00, "R1 status reset value", 32'(rd), 0);

      // R2 random writes with random upper bits; R9 status writes ignored
      for (int i = 0; i < 24; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         bus_write(1'b0, d);
         bus_read(1'b0, rd);
         chk(rd === {5'b0, d[2:0]}, "R2 select write/read", 32'(rd), 32'({5'b0, d[2:0]}));
         bus_write(1'b1, 8'($urandom));
         bus_read(1'b1, rd);
         chk(rd === 8'h00, "R9 status write ignored", 32'(rd), 0);
      end

      // R3/R6/R7 shortest wait with crystal clock and a refused write
      run_wait(3'd1, 1'b1, 1'b1);
      // R6 counter saturates: longer thresholds stay clear
      repeat (3000) @(posedge clk);
      bus_read(1'b1, rd);
      chk(rd === 8'h01, "R6 no flags beyond limit", 32'(rd), 32'h01);
      // R9 status write after a wait
      bus_write(1'b1, 8'hFF);
      bus_read(1'b1, rd);
      chk(rd === 8'h01, "R9 status write ignored after wait", 32'(rd), 32'h01);
      // R8 stray release ignored
      @(negedge clk);
      stop_release = 1'b1;
      @(negedge clk);
      stop_release = 1'b0;
      repeat (3) @(negedge clk);
      chk(ready === 1'b1 && cpu_hold === 1'b0, "R8 stray release ignored",
          32'({ready, cpu_hold}), 32'h2);
      bus_read(1'b1, st_before);
      chk(st_before === 8'h01, "R8 status kept after stray release", 32'(st_before), 1);

      // R3/R5 internal clock, then remaining lengths
      run_wait(3'd2, 1'b0, 1'b0);
      c = 3'd3;
      run_wait(c, 1'($urandom), 1'b0);
      run_wait(3'd4, 1'b1, 1'b0);
      // R4 prohibited code gives the longest wait
      run_wait(3'd6, 1'b1, 1'b0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule